// File: doc/BRIEF.md
# Fanout and Delay Register Chain

This block copies one 32-bit word stream onto four outputs, each of which sees the stream after its own delay. Downstream arithmetic elements often need operands that were produced at different pipeline depths. Choosing a delay per output lines those operands up in time without any flow control. A new word enters on every clock. There is no stall or backpressure path.

The word that enters the chain comes from one of two sources. The first is the local input. The second is the cascade input, which is wired to the tail of a neighbouring chain. Linking chains this way gives more copies of one stream or a longer total delay. The source select and the four tap selects are set when the accelerator is composed and stay fixed while it runs. Each word travels with a valid bit, and every output reports the valid bit that belongs to its tapped word.

Top module: `fanout_delay_chain`

## Requirements
- R1: While `rst_n` is low, a clock edge clears every stage. After such an edge, every `out_valid` bit, every `out_data` word, `casc_valid` and `casc_data` read zero.
- R2: When `src_sel` is 0, the chain takes `in_data`/`in_valid` at each clock edge. When `src_sel` is 1, it takes `prev_data`/`prev_valid`.
- R3: Output j is bits [32j+31:32j] of `out_data` and bit j of `out_valid`. Its tap select is bits [4j+3:4j] of `tap_sel`. A tap value k presents the word and valid bit accepted k+1 clock edges earlier.
- R4: The four outputs choose their taps independently. Outputs set to the same tap carry identical data and valid.
- R5: `casc_data`/`casc_valid` present the word and valid bit accepted 16 clock edges earlier.
- R6: The source that is not selected has no effect on any output.
- R7: An output whose tap select is 15 equals the cascade output in every cycle.
- R8: A word moves down the chain whether its valid bit is set or not, and its valid bit moves with it.
- R9: The chain accepts a new word on every clock edge, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 32 | Local input word |
| in_valid | input | 1 | Local input valid |
| prev_data | input | 32 | Cascade input word from the neighbouring chain's tail |
| prev_valid | input | 1 | Cascade input valid |
| src_sel | input | 1 | 0 selects the local input, 1 selects the cascade input |
| tap_sel | input | 16 | Four 4-bit tap selects, output j in bits [4j+3:4j] |
| out_data | output | 128 | Four output words, output j in bits [32j+31:32j] |
| out_valid | output | 4 | Valid bit of each output |
| casc_data | output | 32 | Last stage word, for the next chain's cascade input |
| casc_valid | output | 1 | Last stage valid |

## Verification
Two things can happen in the same cycle: the source select flips mid-stream, while outputs whose taps straddle that point still show words taken from the old source. The bench switches `src_sel` every few cycles while taps 1, 2, 14 and 15 are active. It feeds distinct random words on both inputs, so a word from the wrong source cannot match by chance. A behavioural history queue predicts the output, and every output is compared on every clock. A second case shares one cycle between a tap-15 output and the cascade tail, and the bench checks that the two are equal.

// File: rtl/chain_pkg.sv
// Package: shared definitions for the fanout and delay register chain.
// Assumes: the source select is one bit, and tap fields are packed low output first.
package chain_pkg;

    // Source choice for the head of the chain
    typedef enum logic {
        SRC_LOCAL   = 1'b0,
        SRC_CASCADE = 1'b1
    } chain_src_e;

endpackage

// File: rtl/chain_src_mux.sv
// Module: chain_src_mux
// Picks the word and valid bit that enter the chain, from either the local input
// or the cascade input. Assumes the select is static while the accelerator runs.
module chain_src_mux
    import chain_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              sel,
    input  logic [DATA_W-1:0] loc_data,
    input  logic              loc_valid,
    input  logic [DATA_W-1:0] cas_data,
    input  logic              cas_valid,
    output logic [DATA_W-1:0] y_data,
    output logic              y_valid
);

    // Route the chosen source to the chain head
    always_comb begin
        if (chain_src_e'(sel) == SRC_CASCADE) begin
            y_data  = cas_data;
            y_valid = cas_valid;
        end else begin
            y_data  = loc_data;
            y_valid = loc_valid;
        end
    end

endmodule

// File: rtl/chain_shift_reg.sv
// Module: chain_shift_reg
// A DEPTH-stage shift register of words, each stage with its valid bit. It advances
// on every clock with no enable. Stage i holds the word accepted i+1 edges earlier.
// Assumes a synchronous active-low reset that clears data and valid.
module chain_shift_reg #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DATA_W-1:0]         d,
    input  logic                      dv,
    output logic [DEPTH*DATA_W-1:0]   stage_data,
    output logic [DEPTH-1:0]          stage_valid
);

    // Head stage: capture the selected source every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_data[DATA_W-1:0] <= '0;
            stage_valid[0]         <= 1'b0;
        end else begin
            stage_data[DATA_W-1:0] <= d;
            stage_valid[0]         <= dv;
        end
    end

    genvar i;
    generate
        for (i = 1; i < DEPTH; i++) begin : g_stage
            // Stage i: take the previous stage's word and valid bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_data[i*DATA_W +: DATA_W] <= '0;
                    stage_valid[i]                 <= 1'b0;
                end else begin
                    stage_data[i*DATA_W +: DATA_W] <= stage_data[(i-1)*DATA_W +: DATA_W];
                    stage_valid[i]                 <= stage_valid[i-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/chain_tap_mux.sv
// Module: chain_tap_mux
// Selects one stage of the shift register for one output. The path is purely
// combinational, so the delay equals the tap index plus one cycle.
// Assumes the select is static while the accelerator runs.
module chain_tap_mux #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [DEPTH*DATA_W-1:0]   stage_data,
    input  logic [DEPTH-1:0]          stage_valid,
    output logic [DATA_W-1:0]         q,
    output logic                      qv
);

    // Read the selected stage's word and valid bit
    always_comb begin
        q  = stage_data[int'(sel)*DATA_W +: DATA_W];
        qv = stage_valid[sel];
    end

endmodule

// File: rtl/fanout_delay_chain.sv
// Module: fanout_delay_chain (top)
// Copies one word stream onto NUM_OUT outputs, each delayed by its own tap, and
// exports the last stage as a cascade output for a neighbouring chain.
// Assumes src_sel and tap_sel are set when the accelerator is composed and are
// held during a run. There is no flow control: one word enters per clock.
module fanout_delay_chain #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int NUM_OUT = 4,
    localparam int SEL_W  = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           prev_data,
    input  logic                        prev_valid,
    input  logic                        src_sel,
    input  logic [NUM_OUT*SEL_W-1:0]    tap_sel,
    output logic [NUM_OUT*DATA_W-1:0]   out_data,
    output logic [NUM_OUT-1:0]          out_valid,
    output logic [DATA_W-1:0]           casc_data,
    output logic                        casc_valid
);

    logic [DATA_W-1:0]       head_data;
    logic                    head_valid;
    logic [DEPTH*DATA_W-1:0] stg_data;
    logic [DEPTH-1:0]        stg_valid;

    chain_src_mux #(.DATA_W(DATA_W)) src_i (
        .sel       (src_sel),
        .loc_data  (in_data),
        .loc_valid (in_valid),
        .cas_data  (prev_data),
        .cas_valid (prev_valid),
        .y_data    (head_data),
        .y_valid   (head_valid)
    );

    chain_shift_reg #(.DATA_W(DATA_W), .DEPTH(DEPTH)) sr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .d           (head_data),
        .dv          (head_valid),
        .stage_data  (stg_data),
        .stage_valid (stg_valid)
    );

    genvar j;
    generate
        for (j = 0; j < NUM_OUT; j++) begin : g_tap
            chain_tap_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tap_i (
                .sel         (tap_sel[j*SEL_W +: SEL_W]),
                .stage_data  (stg_data),
                .stage_valid (stg_valid),
                .q           (out_data[j*DATA_W +: DATA_W]),
                .qv          (out_valid[j])
            );
        end
    endgenerate

    // Export the tail stage for the next chain
    always_comb begin
        casc_data  = stg_data[(DEPTH-1)*DATA_W +: DATA_W];
        casc_valid = stg_valid[DEPTH-1];
    end

endmodule

// File: rtl/fanout_delay_chain_chk.sv
// Module: fanout_delay_chain_chk
// Port-level assertions for fanout_delay_chain, attached with bind below.
// Assumes the configuration inputs are held while the checks that depend on them run.
module fanout_delay_chain_chk #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int NUM_OUT = 4,
    localparam int SEL_W  = $clog2(DEPTH)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [DATA_W-1:0]           in_data,
    input logic                        in_valid,
    input logic [DATA_W-1:0]           prev_data,
    input logic                        prev_valid,
    input logic                        src_sel,
    input logic [NUM_OUT*SEL_W-1:0]    tap_sel,
    input logic [NUM_OUT*DATA_W-1:0]   out_data,
    input logic [NUM_OUT-1:0]          out_valid,
    input logic [DATA_W-1:0]           casc_data,
    input logic                        casc_valid
);

    logic reset_seen;
    logic alive;

    // Note whether the last edge ran with reset active
    always_ff @(posedge clk) reset_seen <= !rst_n;

    // Note whether the previous edge was already out of reset
    always_ff @(posedge clk) alive <= rst_n;

    // R1: after a reset edge, all outputs read zero
    always @(negedge clk) begin
        if (reset_seen === 1'b1 && rst_n === 1'b0) begin
            p_reset_clear_r1: assert (out_valid == '0 && out_data == '0 &&
                                      !casc_valid && casc_data == '0)
                else $error("R1 outputs not cleared");
        end
    end

    // R2: tap 0 on output 0 shows the local input one edge later
    p_local_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel && tap_sel[SEL_W-1:0] == '0) ##1 (tap_sel[SEL_W-1:0] == '0)
        |-> (out_data[DATA_W-1:0] == $past(in_data) && out_valid[0] == $past(in_valid)));

    // R2: tap 0 on output 0 shows the cascade input one edge later
    p_casc_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && tap_sel[SEL_W-1:0] == '0) ##1 (tap_sel[SEL_W-1:0] == '0)
        |-> (out_data[DATA_W-1:0] == $past(prev_data) && out_valid[0] == $past(prev_valid)));

    genvar j;
    generate
        for (j = 1; j < NUM_OUT; j++) begin : g_step
            // R3: a tap one deeper than output 0 shows output 0's previous value
            p_tap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (alive && $stable(tap_sel) &&
                 int'(tap_sel[j*SEL_W +: SEL_W]) == int'(tap_sel[SEL_W-1:0]) + 1)
                |-> (out_data[j*DATA_W +: DATA_W] == $past(out_data[DATA_W-1:0]) &&
                     out_valid[j] == $past(out_valid[0])));
        end
        for (j = 0; j < NUM_OUT; j++) begin : g_tail
            // R7: the deepest tap matches the cascade output
            p_tail_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(tap_sel[j*SEL_W +: SEL_W]) == DEPTH-1)
                |-> (out_data[j*DATA_W +: DATA_W] == casc_data && out_valid[j] == casc_valid));
        end
    endgenerate

endmodule

bind fanout_delay_chain fanout_delay_chain_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_OUT(NUM_OUT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .prev_data  (prev_data),
    .prev_valid (prev_valid),
    .src_sel    (src_sel),
    .tap_sel    (tap_sel),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .casc_data  (casc_data),
    .casc_valid (casc_valid)
);

// File: tb/fanout_delay_chain_tb_top.sv
// Bench for fanout_delay_chain: a behavioural history queue predicts every output,
// and the bench compares them on each falling clock edge.
module fanout_delay_chain_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int DP = 16;
    localparam int NO = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DW-1:0]   in_data = '0;
    logic            in_valid = 1'b0;
    logic [DW-1:0]   prev_data = '0;
    logic            prev_valid = 1'b0;
    logic            src_sel = 1'b0;
    logic [NO*4-1:0] tap_sel = '0;
    logic [NO*DW-1:0] out_data;
    logic [NO-1:0]   out_valid;
    logic [DW-1:0]   casc_data;
    logic            casc_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string req = "R1";

    // History of accepted words, newest first, each as {valid, data}
    logic [DW:0] hist[$];

    fanout_delay_chain dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid),
        .prev_data(prev_data), .prev_valid(prev_valid),
        .src_sel(src_sel), .tap_sel(tap_sel),
        .out_data(out_data), .out_valid(out_valid),
        .casc_data(casc_data), .casc_valid(casc_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: record what the chain should accept on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < DP; i++) hist.push_back('0);
        end else begin
            hist.push_front(src_sel ? {prev_valid, prev_data} : {in_valid, in_data});
            void'(hist.pop_back());
        end
    end

    task automatic check_eq(string tag, string what, logic [DW:0] act, logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic compare_all();
        for (int j = 0; j < NO; j++) begin
            int k = int'(tap_sel[j*4 +: 4]);
            check_eq(req, $sformatf("out%0d tap%0d", j, k),
                     {out_valid[j], out_data[j*DW +: DW]}, hist[k]);
        end
        check_eq(req, "cascade R5", {casc_valid, casc_data}, hist[DP-1]);
    endtask

    // One cycle: wait for the falling edge, compare, then drive fresh inputs
    task automatic cyc(bit rnd_valid);
        @(negedge clk);
        compare_all();
        in_data    = $urandom;
        prev_data  = $urandom;
        in_valid   = rnd_valid ? 1'($urandom) : 1'b1;
        prev_valid = rnd_valid ? 1'($urandom) : 1'b1;
    endtask

    function automatic logic [15:0] taps(int a, int b, int c, int d);
        return {4'(d), 4'(c), 4'(b), 4'(a)};
    endfunction

    initial begin
        // R1: reset clears everything, even with data on the inputs
        rst_n = 1'b0;
        in_data = 32'hDEADBEEF; in_valid = 1'b1;
        tap_sel = taps(0, 5, 10, 15);
        repeat (3) @(posedge clk);
        @(negedge clk);
        req = "R1";
        check_eq("R1", "valid vector", {28'b0, out_valid, casc_valid}, '0);
        check_eq("R1", "out data", {1'b0, out_data[DW-1:0] | out_data[NO*DW-1 -: DW]}, '0);
        check_eq("R1", "cascade data", {1'b0, casc_data}, '0);
        rst_n = 1'b1;

        // R3 R8 R9: local source, mixed taps, random valid bits, new word every cycle
        req = "R3 R8 R9";
        src_sel = 1'b0;
        tap_sel = taps(0, 3, 7, 15);
        repeat (60) cyc(1'b1);

        // R3: sweep every tap value on each output
        req = "R3";
        for (int k = 0; k < DP; k++) begin
            tap_sel = taps(k, (k + 4) % DP, (k + 8) % DP, (k + 12) % DP);
            repeat (3) cyc(1'b1);
        end

        // R2 R6: cascade source while the local input carries junk
        req = "R2 R6";
        src_sel = 1'b1;
        tap_sel = taps(0, 1, 8, 15);
        repeat (40) cyc(1'b1);

        // R6: local source while the cascade input carries junk
        req = "R6";
        src_sel = 1'b0;
        repeat (30) cyc(1'b1);

        // R2: source switches mid-stream while taps straddle the change
        req = "R2";
        tap_sel = taps(1, 2, 14, 15);
        for (int n = 0; n < 8; n++) begin
            src_sel = ~src_sel;
            repeat (5) cyc(1'b1);
        end

        // R4: all outputs on the same tap carry identical values
        req = "R4";
        tap_sel = taps(9, 9, 9, 9);
        repeat (25) begin
            cyc(1'b1);
            for (int j = 1; j < NO; j++)
                check_eq("R4", $sformatf("out%0d vs out0", j),
                         {out_valid[j], out_data[j*DW +: DW]},
                         {out_valid[0], out_data[DW-1:0]});
        end

        // R5 R7: deepest taps match the cascade output in the same cycle
        req = "R5 R7";
        tap_sel = taps(15, 15, 5, 15);
        repeat (30) begin
            cyc(1'b1);
            check_eq("R7", "out0 vs cascade", {out_valid[0], out_data[DW-1:0]},
                     {casc_valid, casc_data});
        end

        // R1: reset mid-stream clears the chain again
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_eq("R1", "valid vector after mid reset", {28'b0, out_valid, casc_valid}, '0);
        rst_n = 1'b1;
        req = "R8";
        tap_sel = taps(0, 2, 4, 15);
        repeat (40) cyc(1'b1);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule